// File: doc/BRIEF.md
# Early-Terminating Multiply-Accumulate Unit

This unit performs 32x32 multiplies, signed or unsigned, and multiply-accumulates into a 40-bit internal accumulator. The number of cycles an operation occupies is chosen when the operation starts. The choice depends on how many upper bits of the multiplier operand (`b_i`) are redundant sign or zero extension, so small multipliers finish sooner. A long multiply returns its low and high result words on separate cycles, each with its own valid strobe. A busy flag tells the issuing logic when a new start would be refused.

Operations are issued with a one-cycle `start_i` strobe carrying an opcode, the two operands and, for multiplies, a long-result select. The accumulator keeps its value between operations. It can be loaded from the two operands and read back as two words.

Top module: `mac_et_unit`

## Requirements
- R1: During and after reset `busy_o`, `lo_valid_o` and `hi_valid_o` are low and the accumulator holds zero.
- R2: Timing convention: a start is taken at the rising edge where `start_i` is high and `busy_o` is low. Latency N means the strobe is high in the Nth cycle after that edge, counting from 1. For op 0 (unsigned multiply) with `long_i`=1, `{hi_o,lo_o}` is the unsigned 64-bit product `a_i*b_i`. Latencies by `b_i` are: `b_i[31:15]` all zero gives low word at 2 and high at 3; otherwise `b_i[31:27]` all zero gives 3 and 4; otherwise 4 and 5.
- R3: Op 1 (signed multiply) with `long_i`=1 gives the signed 64-bit product. It uses the same latencies as R2, but each test passes when the upper bits are all zeros or all ones.
- R4: With `long_i`=0, ops 0 and 1 return only the low word, at the R2/R3 low-word latency. `hi_valid_o` stays low and the unit frees on that cycle.
- R5: Op 2 adds the signed 64-bit product, truncated to 40 bits, to the accumulator. Latency is 1 if `b_i[31:16]` is all zeros or all ones, else 2 if `b_i[31:28]` is all zeros or all ones, else 3. Both strobes rise together. `lo_o` is then accumulator bits 31:0 and `hi_o` is bits 39:32 sign-extended to 32 bits.
- R6: Op 3 adds the signed product of the low halfwords and always takes 1 cycle. Op 4 adds the sum of the low-halfword and high-halfword signed products and always takes 2 cycles. Strobes and result words are as in R5.
- R7: Op 5 loads the accumulator with `{b_i[7:0], a_i}`. It occupies the unit for 2 cycles and raises no strobe.
- R8: Op 6 reads the accumulator: `lo_o` (bits 31:0) at latency 2 and `hi_o` (bits 39:32 sign-extended) at latency 3. The accumulator is unchanged.
- R9: A start while `busy_o` is high, or a start with op 7, is ignored: no strobe, and the accumulator and pending results are unchanged.
- R10: After a start, `busy_o` stays high until the cycle in which the final result word is valid, or for op 5 until its second cycle. `busy_o` is low in that cycle, so back-to-back operations issue one per latency.
- R11: The accumulator wraps modulo 2^40 on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe |
| op_i | input | 3 | Opcode (0..7, see requirements) |
| long_i | input | 1 | Long-result select for ops 0 and 1 |
| a_i | input | 32 | Multiplicand / accumulator low load word |
| b_i | input | 32 | Multiplier (early-termination probe) / accumulator high load byte |
| busy_o | output | 1 | Unit occupied; starts refused |
| lo_valid_o | output | 1 | Low result word valid |
| lo_o | output | 32 | Low result word |
| hi_valid_o | output | 1 | High result word valid |
| hi_o | output | 32 | High result word |

## Verification
Each operation's low-word, high-word and release cycle is predicted from the multiplier's upper bits before it is issued: 1 to 3 cycles for accumulates, 2 to 5 for long multiplies, and 2 or 3 for accumulator access. Inputs change on falling edges. After the accepting edge, every cycle up to the release is sampled on the falling edge. In each sample the two strobes and the busy flag are compared against the predicted cycle, and a word is compared only in its predicted cycle. The next operation is issued in the same cycle busy is seen low, so the throughput counts are checked as well.

// File: rtl/mac_et_pkg.sv
package mac_et_pkg;

    localparam int LAT_W = 3;

    // Fixed latencies of the operations without an early-termination probe
    localparam int MUL_LO_BASE = 2;
    localparam int MUL_HI_BASE = 3;
    localparam int HALF_LEN    = 1;
    localparam int DUAL_LEN    = 2;
    localparam int LOAD_LEN    = 2;
    localparam int READ_LO     = 2;
    localparam int READ_HI     = 3;

    typedef enum logic [2:0] {
        OP_MULU  = 3'd0,
        OP_MULS  = 3'd1,
        OP_MACC  = 3'd2,
        OP_MACH  = 3'd3,
        OP_MACD  = 3'd4,
        OP_LOAD  = 3'd5,
        OP_READ  = 3'd6,
        OP_NONE  = 3'd7
    } op_e;

    typedef struct packed {
        logic             lo_en;
        logic             hi_en;
        logic [LAT_W-1:0] lo;
        logic [LAT_W-1:0] hi;
        logic [LAT_W-1:0] tot;
    } lat_t;

endpackage

// File: rtl/mac_et_lat_sel.sv
module mac_et_lat_sel
    import mac_et_pkg::*;
#(
    parameter int DW        = 32,
    parameter int MUL_CUT_A = 15,
    parameter int MUL_CUT_B = 27,
    parameter int MAC_CUT_A = 16,
    parameter int MAC_CUT_B = 28
) (
    input  op_e           op_i,
    input  logic          long_i,
    input  logic [DW-1:0] mplr_i,
    output lat_t          lat_o
);

    function automatic logic zero_above(input logic [DW-1:0] v, input int k);
        return (v >> k) == '0;
    endfunction

    function automatic logic ones_above(input logic [DW-1:0] v, input int k);
        return ((~v) >> k) == '0;
    endfunction

    logic             mul_sgn;
    logic             mul_a_d, mul_b_d, mac_a_d, mac_b_d;
    logic [LAT_W-1:0] mul_extra_d, mac_len_d;

    always_comb begin
        mul_sgn = (op_i == OP_MULS);
        mul_a_d = zero_above(mplr_i, MUL_CUT_A) || (mul_sgn && ones_above(mplr_i, MUL_CUT_A));
        mul_b_d = zero_above(mplr_i, MUL_CUT_B) || (mul_sgn && ones_above(mplr_i, MUL_CUT_B));
        mac_a_d = zero_above(mplr_i, MAC_CUT_A) || ones_above(mplr_i, MAC_CUT_A);
        mac_b_d = zero_above(mplr_i, MAC_CUT_B) || ones_above(mplr_i, MAC_CUT_B);

        mul_extra_d = mul_a_d ? LAT_W'(0) : (mul_b_d ? LAT_W'(1) : LAT_W'(2));
        mac_len_d   = mac_a_d ? LAT_W'(1) : (mac_b_d ? LAT_W'(2) : LAT_W'(3));

        lat_o = '0;
        case (op_i)
            OP_MULU, OP_MULS: begin
                lat_o.lo_en = 1'b1;
                lat_o.hi_en = long_i;
                lat_o.lo    = LAT_W'(MUL_LO_BASE) + mul_extra_d;
                lat_o.hi    = LAT_W'(MUL_HI_BASE) + mul_extra_d;
                lat_o.tot   = long_i ? lat_o.hi : lat_o.lo;
            end
            OP_MACC: begin
                lat_o.lo_en = 1'b1;
                lat_o.hi_en = 1'b1;
                lat_o.lo    = mac_len_d;
                lat_o.hi    = mac_len_d;
                lat_o.tot   = mac_len_d;
            end
            OP_MACH, OP_MACD: begin
                lat_o.lo_en = 1'b1;
                lat_o.hi_en = 1'b1;
                lat_o.lo    = (op_i == OP_MACH) ? LAT_W'(HALF_LEN) : LAT_W'(DUAL_LEN);
                lat_o.hi    = lat_o.lo;
                lat_o.tot   = lat_o.lo;
            end
            OP_LOAD: begin
                lat_o.tot   = LAT_W'(LOAD_LEN);
            end
            OP_READ: begin
                lat_o.lo_en = 1'b1;
                lat_o.hi_en = 1'b1;
                lat_o.lo    = LAT_W'(READ_LO);
                lat_o.hi    = LAT_W'(READ_HI);
                lat_o.tot   = LAT_W'(READ_HI);
            end
            default: lat_o = '0;
        endcase
    end

endmodule

// File: rtl/mac_et_arith.sv
module mac_et_arith
    import mac_et_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 40
) (
    input  op_e             op_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic [AW-1:0]   acc_i,
    output logic [2*DW-1:0] res_o,
    output logic [AW-1:0]   acc_o
);

    localparam int PW = 2 * DW;
    localparam int HW = DW / 2;
    localparam int XW = AW - DW;

    logic [PW-1:0] prod_u, prod_s;
    logic [AW-1:0] pp_lo, pp_hi;

    // Both full products are taken modulo 2^PW; the signed one uses sign-extended operands
    assign prod_u = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
    assign prod_s = {{DW{a_i[DW-1]}}, a_i} * {{DW{b_i[DW-1]}}, b_i};

    // Halfword products, sign-extended to the accumulator width
    assign pp_lo = {{(AW-HW){a_i[HW-1]}}, a_i[HW-1:0]} * {{(AW-HW){b_i[HW-1]}}, b_i[HW-1:0]};
    assign pp_hi = {{(AW-HW){a_i[DW-1]}}, a_i[DW-1:HW]} * {{(AW-HW){b_i[DW-1]}}, b_i[DW-1:HW]};

    always_comb begin
        acc_o = acc_i;
        res_o = prod_u;
        case (op_i)
            OP_MULU: res_o = prod_u;
            OP_MULS: res_o = prod_s;
            OP_MACC: acc_o = acc_i + prod_s[AW-1:0];
            OP_MACH: acc_o = acc_i + pp_lo;
            OP_MACD: acc_o = acc_i + pp_lo + pp_hi;
            OP_LOAD: acc_o = {b_i[XW-1:0], a_i};
            default: acc_o = acc_i;
        endcase
        if (op_i != OP_MULU && op_i != OP_MULS) begin
            res_o = {{(PW-AW){acc_o[AW-1]}}, acc_o};
        end
    end

endmodule

// File: rtl/mac_et_unit.sv
module mac_et_unit
    import mac_et_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 40,
    parameter int MUL_CUT_A = 15,
    parameter int MUL_CUT_B = 27,
    parameter int MAC_CUT_A = 16,
    parameter int MAC_CUT_B = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [2:0]    op_i,
    input  logic          long_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic          busy_o,
    output logic          lo_valid_o,
    output logic [DW-1:0] lo_o,
    output logic          hi_valid_o,
    output logic [DW-1:0] hi_o
);

    localparam int PW = 2 * DW;

    typedef struct packed {
        logic             busy;
        logic [LAT_W-1:0] cnt;
        lat_t             lat;
        op_e              op;
        logic             lo_vld;
        logic             hi_vld;
        logic [PW-1:0]    res;
        logic [AW-1:0]    acc;
    } st_t;

    op_e           op_in;
    lat_t          lat_new;
    logic [PW-1:0] res_new;
    logic [AW-1:0] acc_new;
    st_t           st_q, st_d;
    logic          accept_d, active_d;

    assign op_in = op_e'(op_i);

    mac_et_lat_sel #(
        .DW        (DW),
        .MUL_CUT_A (MUL_CUT_A),
        .MUL_CUT_B (MUL_CUT_B),
        .MAC_CUT_A (MAC_CUT_A),
        .MAC_CUT_B (MAC_CUT_B)
    ) u_lat (
        .op_i   (op_in),
        .long_i (long_i),
        .mplr_i (b_i),
        .lat_o  (lat_new)
    );

    mac_et_arith #(
        .DW (DW),
        .AW (AW)
    ) u_arith (
        .op_i  (op_in),
        .a_i   (a_i),
        .b_i   (b_i),
        .acc_i (st_q.acc),
        .res_o (res_new),
        .acc_o (acc_new)
    );

    always_comb begin
        st_d        = st_q;
        st_d.lo_vld = 1'b0;
        st_d.hi_vld = 1'b0;
        accept_d    = start_i && !st_q.busy && (op_in != OP_NONE);
        active_d    = 1'b0;
        if (accept_d) begin
            st_d.op  = op_in;
            st_d.lat = lat_new;
            st_d.cnt = LAT_W'(1);
            st_d.res = res_new;
            st_d.acc = acc_new;
            active_d = 1'b1;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + LAT_W'(1);
            active_d = 1'b1;
        end
        if (active_d) begin
            st_d.lo_vld = st_d.lat.lo_en && (st_d.cnt == st_d.lat.lo);
            st_d.hi_vld = st_d.lat.hi_en && (st_d.cnt == st_d.lat.hi);
            st_d.busy   = st_d.cnt < st_d.lat.tot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o     = st_q.busy;
    assign lo_valid_o = st_q.lo_vld;
    assign hi_valid_o = st_q.hi_vld;
    assign lo_o       = st_q.res[DW-1:0];
    assign hi_o       = st_q.res[PW-1:DW];

    // A lone high-word strobe always follows a low-word strobe one cycle earlier
    p_hi_follows_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_valid_o && !lo_valid_o) |-> $past(lo_valid_o));

    // Release coincides with the final strobe, except for the accumulator load
    p_release_final_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (lo_valid_o || hi_valid_o || st_q.op == OP_LOAD));

    // The high word, when present, is always the last one
    p_hi_is_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hi_valid_o |-> !busy_o);

    // While occupied the step counter never reaches the release count early
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.cnt < st_q.lat.tot));

    // A start against a busy unit disturbs neither results nor accumulator
    p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(st_q.acc) && $stable(st_q.res)));

endmodule

// File: tb/mac_et_unit_tb.sv
`timescale 1ns/1ps
module mac_et_unit_tb;

    localparam logic [2:0] K_MULU = 3'd0;
    localparam logic [2:0] K_MULS = 3'd1;
    localparam logic [2:0] K_MACC = 3'd2;
    localparam logic [2:0] K_MACH = 3'd3;
    localparam logic [2:0] K_MACD = 3'd4;
    localparam logic [2:0] K_LOAD = 3'd5;
    localparam logic [2:0] K_READ = 3'd6;
    localparam logic [2:0] K_NONE = 3'd7;

    typedef struct packed {
        logic [2:0]  op;
        logic        lng;
        logic [31:0] a;
        logic [31:0] b;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{K_MULU, 1'b1, 32'hFFFF_FFFF, 32'h0000_7FFF},
        '{K_MULU, 1'b1, 32'h1234_5678, 32'h07FF_FFFF},
        '{K_MULU, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        '{K_MULU, 1'b1, 32'h0000_0003, 32'h0000_8000},
        '{K_MULS, 1'b1, 32'hFFFF_FFFE, 32'hFFFF_8000},
        '{K_MULS, 1'b1, 32'h0000_0007, 32'hF800_0000},
        '{K_MULS, 1'b1, 32'h8000_0000, 32'h8000_0000},
        '{K_MULU, 1'b0, 32'h0000_ABCD, 32'h0001_0000},
        '{K_MULS, 1'b0, 32'hFFFF_FFFF, 32'h0000_0005},
        '{K_MACC, 1'b0, 32'd1000,      32'hFFFF_FFFD},
        '{K_MACC, 1'b0, 32'h0001_0000, 32'h0800_0000},
        '{K_MACC, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF},
        '{K_MACH, 1'b0, 32'h1234_8000, 32'h5678_7FFF},
        '{K_MACD, 1'b0, 32'h0003_FFFF, 32'h0004_0002},
        '{K_READ, 1'b0, 32'h0,         32'h0},
        '{K_LOAD, 1'b0, 32'hFFFF_FFFF, 32'h0000_007F},
        '{K_MACC, 1'b0, 32'h0000_0001, 32'h0000_0001},
        '{K_READ, 1'b0, 32'h0,         32'h0},
        '{K_MACC, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        '{K_MULS, 1'b1, 32'h0000_0005, 32'hFFFF_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic        long_i = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        busy_o, lo_valid_o, hi_valid_o;
    logic [31:0] lo_o, hi_o;

    int          n_chk = 0;
    int          n_err = 0;
    logic [39:0] acc_m = '0;

    always #5 clk = ~clk;

    mac_et_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_i       (op_i),
        .long_i     (long_i),
        .a_i        (a_i),
        .b_i        (b_i),
        .busy_o     (busy_o),
        .lo_valid_o (lo_valid_o),
        .lo_o       (lo_o),
        .hi_valid_o (hi_valid_o),
        .hi_o       (hi_o)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic upz(input logic [31:0] v, input int k);
        return (v >> k) == 32'h0;
    endfunction

    function automatic logic upo(input logic [31:0] v, input int k);
        return ((~v) >> k) == 32'h0;
    endfunction

    task automatic run_op(input logic [2:0] op, input logic lng, input logic [31:0] a,
                          input logic [31:0] b, input int poke, input string tag_ovr);
        int          lo_l, hi_l, tot, cls;
        logic        lo_e, hi_e;
        logic [63:0] exp, p;
        logic [39:0] h0, h1;
        string       tag;
        lo_l = 0; hi_l = 0; tot = 0; cls = 0; lo_e = 0; hi_e = 0; exp = '0; tag = "R8";
        p  = {{32{a[31]}}, a} * {{32{b[31]}}, b};
        h0 = {{24{a[15]}}, a[15:0]} * {{24{b[15]}}, b[15:0]};
        h1 = {{24{a[31]}}, a[31:16]} * {{24{b[31]}}, b[31:16]};
        if (op == K_MULU || op == K_MULS) begin
            if (op == K_MULU) cls = upz(b, 15) ? 0 : (upz(b, 27) ? 1 : 2);
            else cls = (upz(b, 15) || upo(b, 15)) ? 0 : ((upz(b, 27) || upo(b, 27)) ? 1 : 2);
            lo_l = 2 + cls; hi_l = 3 + cls; lo_e = 1; hi_e = lng;
            tot  = lng ? hi_l : lo_l;
            exp  = (op == K_MULU) ? ({32'h0, a} * {32'h0, b}) : p;
            tag  = !lng ? "R4" : ((op == K_MULU) ? "R2" : "R3");
        end else begin
            if (op == K_MACC) begin
                tot = (upz(b, 16) || upo(b, 16)) ? 1 : ((upz(b, 28) || upo(b, 28)) ? 2 : 3);
                acc_m = acc_m + p[39:0];
                tag = "R5";
            end else if (op == K_MACH) begin
                tot = 1; acc_m = acc_m + h0; tag = "R6";
            end else if (op == K_MACD) begin
                tot = 2; acc_m = acc_m + h0 + h1; tag = "R6";
            end else if (op == K_LOAD) begin
                tot = 2; acc_m = {b[7:0], a}; tag = "R7";
            end else begin
                tot = 3; tag = "R8";
            end
            lo_e = (op != K_LOAD); hi_e = lo_e;
            lo_l = (op == K_READ) ? 2 : tot;
            hi_l = tot;
            exp  = {{24{acc_m[39]}}, acc_m};
        end
        if (tag_ovr != "") tag = tag_ovr;
        op_i = op; long_i = lng; a_i = a; b_i = b; start_i = 1'b1;
        @(posedge clk);
        for (int n = 1; n <= tot; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            chk(busy_o == (n < tot), "R10", "busy", 64'(busy_o), 64'(n < tot));
            chk(lo_valid_o == (lo_e && n == lo_l), tag, "lo_valid", 64'(lo_valid_o), 64'(lo_e && n == lo_l));
            chk(hi_valid_o == (hi_e && n == hi_l), tag, "hi_valid", 64'(hi_valid_o), 64'(hi_e && n == hi_l));
            if (lo_e && n == lo_l) chk(lo_o == exp[31:0], tag, "lo word", 64'(lo_o), 64'(exp[31:0]));
            if (hi_e && n == hi_l) chk(hi_o == exp[63:32], tag, "hi word", 64'(hi_o), 64'(exp[63:32]));
            if (n == poke) begin
                start_i = 1'b1; op_i = K_LOAD; a_i = 32'hDEAD_BEEF; b_i = 32'h0000_0055;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk(!busy_o && !lo_valid_o && !hi_valid_o, "R1", "reset outputs",
            64'({busy_o, lo_valid_o, hi_valid_o}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !lo_valid_o && !hi_valid_o, "R1", "idle after reset",
            64'({busy_o, lo_valid_o, hi_valid_o}), 64'h0);
        // R1: accumulator reads back zero
        run_op(K_READ, 1'b0, 32'h0, 32'h0, 0, "R1");

        for (int i = 0; i < NV; i++) begin
            // entry 16 overflows the accumulator loaded by entry 15 (R11)
            run_op(VEC[i].op, VEC[i].lng, VEC[i].a, VEC[i].b, 0, (i == 16) ? "R11" : "");
        end

        // R9: start while busy is refused; accumulator unchanged afterwards
        run_op(K_MULU, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, "R9");
        run_op(K_READ, 1'b0, 32'h0, 32'h0, 0, "R9");

        // R9: opcode 7 is never accepted
        op_i = K_NONE; a_i = 32'h1111_1111; b_i = 32'h2222_2222; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o && !lo_valid_o && !hi_valid_o, "R9", "op7 ignored",
            64'({busy_o, lo_valid_o, hi_valid_o}), 64'h0);
        @(negedge clk);
        chk(!busy_o && !lo_valid_o && !hi_valid_o, "R9", "op7 still quiet",
            64'({busy_o, lo_valid_o, hi_valid_o}), 64'h0);
        run_op(K_READ, 1'b0, 32'h0, 32'h0, 0, "R9");

        // R7 then R8: load a negative accumulator and read it back
        run_op(K_LOAD, 1'b0, 32'h0000_0010, 32'h0000_0080, 0, "R7");
        run_op(K_READ, 1'b0, 32'h0, 32'h0, 0, "R7");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule